// File: doc/BRIEF.md
# Channel Event and Interrupt Flag Unit

This block keeps a small bank of event flags that a host processor and one DMA channel use to pace each other. The host raises a flag with a single write strobe and an index. The channel can wait on a flag: it stalls until the flag is up, then takes the flag down and carries on. A wait may also request a flush of the channel's instruction cache, which lets the host rewrite the channel program between blocks.

The channel can also signal an event. When interrupt routing is enabled for that event, the signal becomes a sticky interrupt line towards the host, which stays up until the host clears it. When routing is disabled, the signal raises the event flag itself. A write-barrier input holds back a signal until all queued writes have landed, so an end-of-task interrupt cannot overtake the data it announces.

Top module: `evt_irq_unit`

## Requirements
- R1: There are 8 event flags, indexed 0 to 7, all clear after reset. After reset `ch_stall`, `irq_out` and `icache_inval` are 0. A host set (`host_set_vld`=1, `host_set_idx`=k) raises flag k at the next clock edge and leaves the other flags unchanged.
- R2: A wait (`ch_wait_req`=1, `ch_wait_idx`=k) on a clear flag keeps `ch_stall` high. If the host sets flag k in cycle s, `ch_stall` is still high in cycle s+1 and low in cycle s+2.
- R3: A wait on a flag that is already set holds `ch_stall` high for exactly its first cycle and drops it in the second. The flag is then clear, so a later wait on it blocks again.
- R4: If the host sets flag k in the cycle in which a wait consumes flag k, the wait wins and the flag ends up clear.
- R5: A wait with `ch_wait_inval`=1 drives `icache_inval` high for exactly one cycle: the cycle in which `ch_stall` drops. A wait with `ch_wait_inval`=0 never drives it.
- R6: A signal (`ch_sig_req`=1, `ch_sig_idx`=k) with no pending writes completes without stalling. If `irq_en[k]`=1, `irq_out[k]` goes high at the next edge and stays high until the host clears it, even if `irq_en[k]` later drops. If `irq_en[k]`=0, no interrupt rises and flag k is raised instead.
- R7: While `wr_pending`=1, or while `ch_wait_req`=1, a signal request stalls the channel and has no effect. It takes effect in the first cycle in which both inputs are 0.
- R8: A host clear (`host_irq_clr_vld`=1, `host_irq_clr_idx`=k) drops `irq_out[k]` at the next edge. A routed signal to the same k in the same cycle wins, and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_set_vld | input | 1 | Host event set strobe |
| host_set_idx | input | 3 | Event index for the host set |
| ch_wait_req | input | 1 | Channel wait request, held until the stall drops |
| ch_wait_idx | input | 3 | Event index for the wait |
| ch_wait_inval | input | 1 | The wait also asks for an instruction-cache flush |
| ch_sig_req | input | 1 | Channel signal request, held until the stall drops |
| ch_sig_idx | input | 3 | Event index for the signal |
| wr_pending | input | 1 | Queued channel writes are not yet complete |
| irq_en | input | 8 | Per-event interrupt routing enable |
| host_irq_clr_vld | input | 1 | Host interrupt clear strobe |
| host_irq_clr_idx | input | 3 | Interrupt line to clear |
| ch_stall | output | 1 | Channel must hold its current request |
| irq_out | output | 8 | Sticky interrupt lines to the host |
| icache_inval | output | 1 | One-cycle instruction-cache flush request |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a host set and a channel wait on the same flag. The second pair is a routed signal and a host clear on the same interrupt line. The bench provokes each pair deliberately. For the first pair, it drives the host set in the exact cycle in which the wait is consuming the flag. It then issues a fresh wait and judges the outcome by the stall length: one cycle means the flag survived, and a stall that is still blocked means the wait won. For the second pair, it drives the clear and the signal together and reads `irq_out` at the next edge. For both pairs the bench also covers the cycle just before, where the set comes first and is expected to win.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Selection test shared by every per-slot update: a strobe aimed at one slot.
  function automatic logic evt_hit(input logic vld, input int idx, input int slot);
    return vld && (idx == slot);
  endfunction

  // Next value of a sticky flag whose clear has priority over its set.
  function automatic logic clr_first(input logic cur, input logic set, input logic clr);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction

  // Next value of a sticky flag whose set has priority over its clear.
  function automatic logic set_first(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_pkg::*;
#(
  parameter int N_EVT = 8,
  localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_set_vld,
  input  logic [IW-1:0]    host_set_idx,
  input  logic             sig_set_vld,
  input  logic [IW-1:0]    sig_set_idx,
  input  logic             consume_vld,
  input  logic [IW-1:0]    consume_idx,
  output logic [N_EVT-1:0] pend_q
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    logic set_any;
    logic clr_me;
    assign set_any = evt_hit(host_set_vld, int'(host_set_idx), i)
                   | evt_hit(sig_set_vld, int'(sig_set_idx), i);
    assign clr_me  = evt_hit(consume_vld, int'(consume_idx), i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= clr_first(pend_q[i], set_any, clr_me);
    end
  end

  // R1: a host set not overruled by a wait lands on the addressed flag
  assert_host_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_set_vld && !(consume_vld && consume_idx == host_set_idx)
    |=> pend_q[$past(host_set_idx)]);

  // R4: a consumed flag is clear afterwards, whatever else targeted it
  assert_consume_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume_vld |=> !pend_q[$past(consume_idx)]);

endmodule

// File: rtl/evt_wait_ctl.sv
module evt_wait_ctl #(
  parameter int N_EVT = 8,
  localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic [IW-1:0]    wait_idx,
  input  logic             wait_inval,
  input  logic [N_EVT-1:0] pend,
  output logic             wait_stall,
  output logic             consume_vld,
  output logic [IW-1:0]    consume_idx,
  output logic             inval_pulse
);

  logic clr_q;    // high in the cycle after a flag was consumed
  logic inval_q;

  assign consume_vld = wait_req && !clr_q && pend[wait_idx];
  assign consume_idx = wait_idx;
  assign wait_stall  = wait_req && !clr_q;
  assign inval_pulse = inval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q   <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      clr_q   <= consume_vld;
      inval_q <= consume_vld && wait_inval;
    end
  end

  // R2: a wait on a clear flag keeps stalling
  assert_blocked_wait_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req && !clr_q && !pend[wait_idx] |-> wait_stall);

  // R3: consuming a flag costs one cycle, then the stall drops
  assert_one_clear_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    consume_vld |=> !wait_stall);

  // R5: the flush request is a single-cycle pulse
  assert_inval_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |=> !inval_pulse);

  // R5: the flush request coincides with the stall dropping
  assert_inval_with_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> !wait_stall);

endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_pkg::*;
#(
  parameter int N_EVT = 8,
  localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_fire,
  input  logic [IW-1:0]    sig_idx,
  input  logic [N_EVT-1:0] irq_en,
  input  logic             clr_vld,
  input  logic [IW-1:0]    clr_idx,
  output logic             sig_to_flag,
  output logic [N_EVT-1:0] irq_q
);

  logic fire_irq;
  assign fire_irq    = sig_fire && irq_en[sig_idx];
  assign sig_to_flag = sig_fire && !irq_en[sig_idx];

  for (genvar i = 0; i < N_EVT; i++) begin : g_line
    logic raise;
    logic drop;
    assign raise = evt_hit(fire_irq, int'(sig_idx), i);
    assign drop  = evt_hit(clr_vld, int'(clr_idx), i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= set_first(irq_q[i], raise, drop);
    end
  end

  // R6: a routed signal raises its interrupt line
  assert_routed_signal_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_irq |=> irq_q[$past(sig_idx)]);

  // R8: a clear not contested by a signal drops the line
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld && !(fire_irq && sig_idx == clr_idx) |=> !irq_q[$past(clr_idx)]);

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
  parameter int N_EVT = 8,
  localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_set_vld,
  input  logic [IW-1:0]    host_set_idx,
  input  logic             ch_wait_req,
  input  logic [IW-1:0]    ch_wait_idx,
  input  logic             ch_wait_inval,
  input  logic             ch_sig_req,
  input  logic [IW-1:0]    ch_sig_idx,
  input  logic             wr_pending,
  input  logic [N_EVT-1:0] irq_en,
  input  logic             host_irq_clr_vld,
  input  logic [IW-1:0]    host_irq_clr_idx,
  output logic             ch_stall,
  output logic [N_EVT-1:0] irq_out,
  output logic             icache_inval
);

  // Named internal events, visible to the assertions
  logic [N_EVT-1:0] pend;
  logic             wait_stall;
  logic             consume_vld;
  logic [IW-1:0]    consume_idx;
  logic             sig_fire;
  logic             sig_to_flag;

  // A signal waits for the write barrier and for any wait in progress
  assign sig_fire = ch_sig_req && !wr_pending && !ch_wait_req;
  assign ch_stall = wait_stall || (ch_sig_req && !sig_fire);

  evt_flag_bank #(.N_EVT(N_EVT)) u_bank (
    .clk, .rst_n,
    .host_set_vld, .host_set_idx,
    .sig_set_vld (sig_to_flag),
    .sig_set_idx (ch_sig_idx),
    .consume_vld, .consume_idx,
    .pend_q      (pend)
  );

  evt_wait_ctl #(.N_EVT(N_EVT)) u_wait (
    .clk, .rst_n,
    .wait_req    (ch_wait_req),
    .wait_idx    (ch_wait_idx),
    .wait_inval  (ch_wait_inval),
    .pend,
    .wait_stall, .consume_vld, .consume_idx,
    .inval_pulse (icache_inval)
  );

  evt_irq_route #(.N_EVT(N_EVT)) u_irq (
    .clk, .rst_n,
    .sig_fire,
    .sig_idx     (ch_sig_idx),
    .irq_en,
    .clr_vld     (host_irq_clr_vld),
    .clr_idx     (host_irq_clr_idx),
    .sig_to_flag,
    .irq_q       (irq_out)
  );

  // R7: a signal held back by the barrier keeps the channel stalled
  assert_barrier_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_sig_req && wr_pending |-> ch_stall);

  // R7: a held-back signal leaves the interrupt lines untouched
  assert_barrier_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_sig_req && (wr_pending || ch_wait_req) && !host_irq_clr_vld |=> $stable(irq_out));

  // R6: an unobstructed signal never stalls the channel
  assert_signal_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sig_fire |-> !ch_stall);

endmodule

// File: tb/evt_irq_unit_test.sv
module evt_irq_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_set_vld = 1'b0;
  logic [2:0] host_set_idx = '0;
  logic       ch_wait_req = 1'b0;
  logic [2:0] ch_wait_idx = '0;
  logic       ch_wait_inval = 1'b0;
  logic       ch_sig_req = 1'b0;
  logic [2:0] ch_sig_idx = '0;
  logic       wr_pending = 1'b0;
  logic [7:0] irq_en = '0;
  logic       host_irq_clr_vld = 1'b0;
  logic [2:0] host_irq_clr_idx = '0;
  logic       ch_stall;
  logic [7:0] irq_out;
  logic       icache_inval;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_irq_unit uut (
    .clk, .rst_n, .host_set_vld, .host_set_idx,
    .ch_wait_req, .ch_wait_idx, .ch_wait_inval,
    .ch_sig_req, .ch_sig_idx, .wr_pending, .irq_en,
    .host_irq_clr_vld, .host_irq_clr_idx,
    .ch_stall, .irq_out, .icache_inval
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_set(input int k);
    host_set_vld = 1'b1; host_set_idx = 3'(k);
    tick();
    host_set_vld = 1'b0;
  endtask

  // Hold a wait; count stalled cycles up to a limit, then release the request
  task automatic run_wait(input int k, input bit inv, input int limit,
                          output int stalls, output bit saw_inval);
    stalls = 0; saw_inval = 1'b0;
    ch_wait_req = 1'b1; ch_wait_idx = 3'(k); ch_wait_inval = inv;
    forever begin
      #1;
      if (!ch_stall) begin
        saw_inval = icache_inval;
        ch_wait_req = 1'b0; ch_wait_inval = 1'b0;
        tick();
        break;
      end
      stalls++;
      if (stalls == limit) begin
        ch_wait_req = 1'b0;
        tick();
        break;
      end
      tick();
    end
  endtask

  task automatic signal(input int k);
    ch_sig_req = 1'b1; ch_sig_idx = 3'(k);
    #1 chk("R6 signal completes without stall", int'(ch_stall), 0);
    tick();
    ch_sig_req = 1'b0;
  endtask

  initial begin
    int  n;
    bit  inv_seen;
    logic [7:0] exp_irq;

    tick(); tick();
    chk("R1 reset stall", int'(ch_stall), 0);
    chk("R1 reset irq", int'(irq_out), 0);
    chk("R1 reset inval", int'(icache_inval), 0);
    rst_n = 1'b1;
    tick();

    // R1/R3: set before wait, one clearing cycle, then the next wait blocks
    for (int k = 0; k < 8; k++) begin
      host_set(k);
      run_wait(k, 1'b0, 4, n, inv_seen);
      chk($sformatf("R3 pre-set wait stalls one cycle ev%0d", k), n, 1);
      chk("R5 no flush without request", int'(inv_seen), 0);
      run_wait(k, 1'b0, 3, n, inv_seen);
      chk($sformatf("R3 second wait blocks ev%0d", k), n, 3);
    end

    // R1: a set on one flag leaves its neighbour clear
    host_set(2);
    run_wait(3, 1'b0, 3, n, inv_seen);
    chk("R1 neighbour flag untouched", n, 3);
    run_wait(2, 1'b0, 4, n, inv_seen);
    chk("R1 set flag kept", n, 1);

    // R2: wait first, host set later
    for (int k = 0; k < 8; k++) begin
      ch_wait_req = 1'b1; ch_wait_idx = 3'(k);
      #1 chk("R2 blocked cycle 0", int'(ch_stall), 1);
      tick();
      #1 chk("R2 blocked cycle 1", int'(ch_stall), 1);
      host_set_vld = 1'b1; host_set_idx = 3'(k);
      tick();
      host_set_vld = 1'b0;
      #1 chk($sformatf("R2 stall in cycle after set ev%0d", k), int'(ch_stall), 1);
      tick();
      #1 chk($sformatf("R2 release two cycles after set ev%0d", k), int'(ch_stall), 0);
      ch_wait_req = 1'b0;
      tick();
    end

    // R4: host set during the consuming cycle; the wait wins
    for (int k = 1; k < 8; k += 3) begin
      host_set(k);
      ch_wait_req = 1'b1; ch_wait_idx = 3'(k);
      host_set_vld = 1'b1; host_set_idx = 3'(k);
      tick();
      host_set_vld = 1'b0;
      #1 chk("R4 wait released", int'(ch_stall), 0);
      ch_wait_req = 1'b0;
      tick();
      run_wait(k, 1'b0, 3, n, inv_seen);
      chk($sformatf("R4 flag clear after contested set ev%0d", k), n, 3);
    end

    // R5: flush pulse with the release, then gone
    host_set(5);
    run_wait(5, 1'b1, 4, n, inv_seen);
    chk("R5 flush wait stall length", n, 1);
    chk("R5 flush in release cycle", int'(inv_seen), 1);
    #1 chk("R5 flush lasts one cycle", int'(icache_inval), 0);

    // R6: routed signals raise sticky lines, one per event
    irq_en = 8'hFF;
    exp_irq = '0;
    for (int k = 0; k < 8; k++) begin
      signal(k);
      exp_irq[k] = 1'b1;
      chk($sformatf("R6 irq after signal ev%0d", k), int'(irq_out), int'(exp_irq));
    end
    irq_en = 8'h00;
    tick();
    chk("R6 lines persist after enable drops", int'(irq_out), 255);

    // R8: host clears, one per event, with a contested clear on 4
    for (int k = 0; k < 8; k++) begin
      if (k == 4) begin
        irq_en = 8'h10;
        ch_sig_req = 1'b1; ch_sig_idx = 3'(4);
      end
      host_irq_clr_vld = 1'b1; host_irq_clr_idx = 3'(k);
      tick();
      host_irq_clr_vld = 1'b0; ch_sig_req = 1'b0; irq_en = 8'h00;
      if (k != 4) exp_irq[k] = 1'b0;
      chk($sformatf("R8 clear ev%0d", k), int'(irq_out), int'(exp_irq));
    end
    host_irq_clr_vld = 1'b1; host_irq_clr_idx = 3'(4);
    tick();
    host_irq_clr_vld = 1'b0;
    chk("R8 line drops on uncontested clear", int'(irq_out), 0);

    // R6: unrouted signal raises the flag, not an interrupt
    signal(6);
    chk("R6 unrouted signal no irq", int'(irq_out), 0);
    run_wait(6, 1'b0, 4, n, inv_seen);
    chk("R6 unrouted signal sets flag", n, 1);

    // R7: write barrier holds the signal back
    irq_en = 8'h08;
    wr_pending = 1'b1;
    ch_sig_req = 1'b1; ch_sig_idx = 3'(3);
    #1 chk("R7 barrier stalls", int'(ch_stall), 1);
    tick(); tick();
    chk("R7 no irq under barrier", int'(irq_out), 0);
    wr_pending = 1'b0;
    #1 chk("R7 released after barrier", int'(ch_stall), 0);
    tick();
    ch_sig_req = 1'b0;
    chk("R7 irq after barrier", int'(irq_out), 8);

    // R7: a wait in progress takes priority over a signal
    irq_en = 8'h01;
    ch_wait_req = 1'b1; ch_wait_idx = 3'(7);
    ch_sig_req = 1'b1; ch_sig_idx = 3'(0);
    tick();
    #1 chk("R7 stall with wait and signal", int'(ch_stall), 1);
    chk("R7 signal held behind wait", int'(irq_out), 8);
    ch_wait_req = 1'b0; ch_sig_req = 1'b0;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule